// File: doc/BRIEF.md
# Radix Page-Table Walker

This block turns a virtual address into a physical address. It walks a radix-tree page table held in memory. A requester gives it a virtual address, the physical base of the top-level table and a depth select. The depth select picks a four-level walk with 48 translated address bits or a five-level walk with 57. The walker then reads one 64-bit table entry at a time through a valid/ready read port. Each entry either points to the next table, ends the walk as a leaf mapping, or ends it with a fault.

Every table holds 512 entries of 8 bytes. Each walk step takes a 9-bit slice of the virtual address as its index. An entry can end the walk early as a large mapping: 2 MB, 1 GB, or 512 GB in five-level mode. For a large mapping, the untranslated low bits of the virtual address pass straight into the physical address. The result carries a fault flag, the physical address and a size code. It stays on the outputs until the requester acknowledges it, and only then does the walker take the next request.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only when no walk is running and no result is pending. A request is captured in a cycle where `req_valid` and `req_ready` are both high.
- R2: At most one table read is outstanding. `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready` is seen. The next read is issued only after the one-cycle `mem_rsp_valid` pulse for the previous read.
- R3: An entry address is the table base plus 8 times the index. The base is bits 51:12 of the root pointer or of the previous entry. Walking down, the indexes are VA bits 47:39, 38:30, 29:21 and 20:12. Five-level mode reads one more table first, indexed by VA bits 56:48.
- R4: With `req_five`=0 the walk starts at the 47:39 table, and VA bits 63:48 have no effect. With `req_five`=1 it starts at the 56:48 table, and VA bits 63:57 have no effect. A full walk therefore takes 4 or 5 reads.
- R5: Entry bit 0 is the present flag. When an entry has bit 0 clear, the walk stops after that read with a fault.
- R6: A present entry with bit 7 set in the table indexed by VA 29:21 is a 2 MB leaf. Then `res_paddr` = {entry[51:21], VA[20:0]} and `res_size`=1.
- R7: A present entry with bit 7 set in the table indexed by VA 38:30 is a 1 GB leaf. Then `res_paddr` = {entry[51:30], VA[29:0]} and `res_size`=2.
- R8: In five-level mode, a present entry with bit 7 set in the table indexed by VA 47:39 is a 512 GB leaf. Then `res_paddr` = {entry[51:39], VA[38:0]} and `res_size`=3.
- R9: Bit 7 set in a top-level entry, in either mode, gives a fault. Bit 7 in an entry of the last table (VA 20:12) is ignored, and that entry is an ordinary 4 KB leaf.
- R10: A last-table entry gives `res_paddr` = {entry[51:12], VA[11:0]} and `res_size`=0. Entry bits 63:52 and bits 11:1, apart from the flags named above, do not affect the address.
- R11: `res_valid`, `res_fault`, `res_paddr` and `res_size` hold steady until `res_ack`. A fault reports `res_paddr`=0 and `res_size`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 52 | Physical base of the top-level table |
| req_five | input | 1 | 1 = five-level walk, 0 = four-level walk |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying the entry |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | Result pending |
| res_ack | input | 1 | Requester takes the result |
| res_fault | output | 1 | Translation fault |
| res_paddr | output | 52 | Physical address |
| res_size | output | 2 | 0=4 KB, 1=2 MB, 2=1 GB, 3=512 GB |

## Verification
Two things can fall in the same cycle: a pending result and a new request from the requester. The bench raises `req_valid` with a second address while the first result is still waiting. It holds `res_ack` low for several cycles and checks at each step that the first result stays unchanged and that `req_ready` stays low. It then acknowledges and checks that the waiting request is taken on the following edge and produces its own correct translation. The table walks also run with read-accept stalls and response gaps, so that the point where a response arrives lands on different cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W      = 64;
    localparam int PA_W      = 52;
    localparam int ENT_W     = 64;
    localparam int IDX_W     = 9;
    localparam int OFF_W     = 12;
    localparam int MAX_LVL   = 5;
    localparam int LVL_W     = $clog2(MAX_LVL + 1);
    localparam int FRAME_W   = PA_W - OFF_W;
    localparam int PRES_BIT  = 0;
    localparam int LEAF_BIT  = 7;

    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_2M   = 2'd1,
        PG_1G   = 2'd2,
        PG_512G = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        ENT_NEXT  = 2'd0,
        ENT_LEAF  = 2'd1,
        ENT_FAULT = 2'd2
    } ent_kind_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_READ = 2'd1,
        W_WAIT = 2'd2,
        W_DONE = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic            fault;
        pg_size_e        size;
        logic [PA_W-1:0] paddr;
    } walk_res_t;

    function automatic lvl_t start_level(input logic five);
        return five ? lvl_t'(5) : lvl_t'(4);
    endfunction

    function automatic frame_t entry_frame(input logic [ENT_W-1:0] e);
        return e[PA_W-1:OFF_W];
    endfunction

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
    import ptw_pkg::*;
#(
    parameter int P_VA_W   = VA_W,
    parameter int P_PA_W   = PA_W,
    parameter int P_IDX_W  = IDX_W,
    parameter int P_OFF_W  = OFF_W,
    parameter int P_LEVELS = MAX_LVL
) (
    input  logic [P_VA_W-1:0]          vaddr_i,
    input  lvl_t                       lvl_i,
    input  logic [P_PA_W-P_OFF_W-1:0]  base_i,
    output logic [P_PA_W-1:0]          addr_o
);
    localparam int ESH = P_OFF_W - P_IDX_W;

    logic [P_IDX_W-1:0] idx_by_lvl [P_LEVELS];
    logic [P_IDX_W-1:0] idx_sel;

    for (genvar g = 0; g < P_LEVELS; g++) begin : g_idx
        assign idx_by_lvl[g] = vaddr_i[P_OFF_W + P_IDX_W*g +: P_IDX_W];
    end

    always_comb begin
        idx_sel = '0;
        for (int k = 0; k < P_LEVELS; k++) begin
            if (lvl_i == lvl_t'(k + 1)) idx_sel = idx_by_lvl[k];
        end
    end

    assign addr_o = {base_i, idx_sel, {ESH{1'b0}}};

endmodule

// File: rtl/ptw_entry_classify.sv
module ptw_entry_classify
    import ptw_pkg::*;
#(
    parameter int P_ENT_W = ENT_W
) (
    input  logic [P_ENT_W-1:0] entry_i,
    input  lvl_t               lvl_i,
    input  lvl_t               top_i,
    output ent_kind_e          kind_o,
    output pg_size_e           size_o
);
    logic present, huge;

    assign present = entry_i[PRES_BIT];
    assign huge    = entry_i[LEAF_BIT];

    always_comb begin
        if (!present)
            kind_o = ENT_FAULT;
        else if (lvl_i == lvl_t'(1))
            kind_o = ENT_LEAF;      // last table: large flag ignored
        else if (huge && lvl_i == top_i)
            kind_o = ENT_FAULT;     // large flag at root is illegal
        else if (huge)
            kind_o = ENT_LEAF;
        else
            kind_o = ENT_NEXT;
    end

    assign size_o = pg_size_e'(2'(lvl_i - lvl_t'(1)));

    always_comb begin
        if (kind_o == ENT_LEAF)
            assert_leaf_level_R9: assert (lvl_i >= lvl_t'(1) && lvl_i <= lvl_t'(MAX_LVL - 1));
    end

endmodule

// File: rtl/ptw_leaf_form.sv
module ptw_leaf_form
    import ptw_pkg::*;
#(
    parameter int P_VA_W   = VA_W,
    parameter int P_PA_W   = PA_W,
    parameter int P_IDX_W  = IDX_W,
    parameter int P_OFF_W  = OFF_W,
    parameter int P_LEVELS = MAX_LVL - 1
) (
    input  logic [P_VA_W-1:0]          vaddr_i,
    input  logic [P_PA_W-P_OFF_W-1:0]  frame_i,
    input  lvl_t                       lvl_i,
    output logic [P_PA_W-1:0]          paddr_o
);
    logic [P_PA_W-1:0] full_frame;
    logic [P_PA_W-1:0] cand [P_LEVELS];

    assign full_frame = {frame_i, {P_OFF_W{1'b0}}};

    for (genvar g = 0; g < P_LEVELS; g++) begin : g_size
        localparam int SH = P_OFF_W + P_IDX_W*g;
        localparam logic [P_PA_W-1:0] LOW = (P_PA_W'(1) << SH) - P_PA_W'(1);
        assign cand[g] = (full_frame & ~LOW) | (vaddr_i[P_PA_W-1:0] & LOW);
    end

    always_comb begin
        paddr_o = '0;
        for (int k = 0; k < P_LEVELS; k++) begin
            if (lvl_i == lvl_t'(k + 1)) paddr_o = cand[k];
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PA_W-1:0]   req_root,
    input  logic              req_five,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ack,
    output logic              res_fault,
    output logic [PA_W-1:0]   res_paddr,
    output logic [1:0]        res_size
);
    walk_state_e      state_q;
    logic [VA_W-1:0]  va_q;
    lvl_t             lvl_q, top_q;
    frame_t           base_q;
    walk_res_t        res_q;

    ent_kind_e        kind;
    pg_size_e         leaf_size;
    logic [PA_W-1:0]  leaf_paddr;
    logic [PA_W-1:0]  entry_addr;

    ptw_index_sel u_idx (
        .vaddr_i (va_q),
        .lvl_i   (lvl_q),
        .base_i  (base_q),
        .addr_o  (entry_addr)
    );

    ptw_entry_classify u_cls (
        .entry_i (mem_rsp_data),
        .lvl_i   (lvl_q),
        .top_i   (top_q),
        .kind_o  (kind),
        .size_o  (leaf_size)
    );

    ptw_leaf_form u_leaf (
        .vaddr_i (va_q),
        .frame_i (entry_frame(mem_rsp_data)),
        .lvl_i   (lvl_q),
        .paddr_o (leaf_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            va_q    <= '0;
            lvl_q   <= '0;
            top_q   <= '0;
            base_q  <= '0;
            res_q   <= '0;
        end else begin
            unique case (state_q)
                W_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    lvl_q   <= start_level(req_five);
                    top_q   <= start_level(req_five);
                    base_q  <= req_root[PA_W-1:OFF_W];
                    state_q <= W_READ;
                end
                W_READ: if (mem_rd_ready) state_q <= W_WAIT;
                W_WAIT: if (mem_rsp_valid) begin
                    unique case (kind)
                        ENT_FAULT: begin
                            res_q   <= '{fault: 1'b1, size: PG_4K, paddr: '0};
                            state_q <= W_DONE;
                        end
                        ENT_LEAF: begin
                            res_q   <= '{fault: 1'b0, size: leaf_size, paddr: leaf_paddr};
                            state_q <= W_DONE;
                        end
                        default: begin
                            base_q  <= entry_frame(mem_rsp_data);
                            lvl_q   <= lvl_q - lvl_t'(1);
                            state_q <= W_READ;
                        end
                    endcase
                end
                W_DONE: if (res_ack) state_q <= W_IDLE;
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assign req_ready    = (state_q == W_IDLE);
    assign mem_rd_valid = (state_q == W_READ);
    assign mem_rd_addr  = entry_addr;
    assign res_valid    = (state_q == W_DONE);
    assign res_fault    = res_q.fault;
    assign res_paddr    = res_q.paddr;
    assign res_size     = res_q.size;

    assert_idle_only_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!res_valid && !mem_rd_valid));

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_one_read_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

    assert_res_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ack) |=> (res_valid && $stable(res_paddr)
                                     && $stable(res_fault) && $stable(res_size)));

    assert_fault_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault) |-> (res_paddr == '0 && res_size == 2'd0));

    assert_offset_pass_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_fault) |-> (res_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;

    typedef struct packed {
        logic [63:0] va;
        logic        five;
        logic        fault;
        logic [1:0]  size;
        logic [51:0] pa;
        logic [3:0]  reads;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0080_8060_4ABC, 1'b0, 1'b0, 2'd0, 52'h0_0000_1234_5ABC, 4'd4},
        '{64'h0000_0080_80A1_2345, 1'b0, 1'b0, 2'd1, 52'h0_0000_4061_2345, 4'd3},
        '{64'h0000_0081_8123_4567, 1'b0, 1'b0, 2'd2, 52'h0_0008_C123_4567, 4'd2},
        '{64'h0000_0081_C000_0000, 1'b0, 1'b1, 2'd0, 52'h0,                4'd2},
        '{64'h0000_0080_8100_0055, 1'b0, 1'b1, 2'd0, 52'h0,                4'd3},
        '{64'h0000_0480_0000_0000, 1'b0, 1'b1, 2'd0, 52'h0,                4'd1},
        '{64'h0000_0080_8060_A123, 1'b0, 1'b0, 2'd0, 52'h0_0000_0777_7123, 4'd4},
        '{64'hFFFF_0080_8060_4ABC, 1'b0, 1'b0, 2'd0, 52'h0_0000_1234_5ABC, 4'd4},
        '{64'h0003_0080_8060_4ABC, 1'b1, 1'b0, 2'd0, 52'h0_0000_1234_5ABC, 4'd5},
        '{64'h0003_0080_80A1_2345, 1'b1, 1'b0, 2'd1, 52'h0_0000_4061_2345, 4'd4},
        '{64'h0003_0081_8123_4567, 1'b1, 1'b0, 2'd2, 52'h0_0008_C123_4567, 4'd3},
        '{64'h0004_0112_3456_789A, 1'b1, 1'b0, 2'd3, 52'h2_0012_3456_789A, 4'd2},
        '{64'h0005_0000_0000_0000, 1'b1, 1'b1, 2'd0, 52'h0,                4'd1},
        '{64'hFE03_0080_8060_4ABC, 1'b1, 1'b0, 2'd0, 52'h0_0000_1234_5ABC, 4'd5},
        '{64'h0006_0000_0000_0000, 1'b1, 1'b1, 2'd0, 52'h0,                4'd1}
    };

    localparam logic [51:0] ROOT4 = 52'h10_0000;
    localparam logic [51:0] ROOT5 = 52'h60_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [51:0] req_root = '0;
    logic        req_five = 1'b0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [51:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ack = 1'b0;
    logic        res_fault;
    logic [51:0] res_paddr;
    logic [1:0]  res_size;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    int stall = 0;
    int gap = 0;
    logic [51:0] first_addr = '0;
    logic [63:0] mem [logic [51:0]];

    always #5 clk = ~clk;

    pt_walker u0 (
        .clk, .rst, .req_valid, .req_ready, .req_vaddr, .req_root, .req_five,
        .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
        .res_valid, .res_ack, .res_fault, .res_paddr, .res_size
    );

    function automatic logic [51:0] ea(input logic [51:0] base, input int idx);
        return base + 52'(idx * 8);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder
    initial begin
        logic [51:0] a;
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                repeat (stall) @(negedge clk);
                mem_rd_ready = 1'b1;
                a = mem_rd_addr;
                if (reads == 0) first_addr = a;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                reads++;
                repeat (gap) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h0;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic send(input logic [63:0] va, input logic five);
        @(negedge clk);
        reads     = 0;
        req_vaddr = va;
        req_five  = five;
        req_root  = five ? ROOT5 : ROOT4;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_res();
        while (!res_valid) @(negedge clk);
    endtask

    task automatic ack();
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
    endtask

    function automatic string vtag(input int i);
        case (i)
            0: return "R10";  1: return "R6";  2: return "R7";  3: return "R5";
            4: return "R5";   5: return "R9";  6: return "R9";  7: return "R4";
            8: return "R4";   9: return "R6"; 10: return "R7"; 11: return "R8";
            12: return "R9"; 13: return "R4"; default: return "R5";
        endcase
    endfunction

    initial begin
        // four-level tables
        mem[ea(52'h10_0000, 1)]  = 64'h20_0001;
        mem[ea(52'h10_0000, 9)]  = 64'h90_0081;
        mem[ea(52'h20_0000, 2)]  = 64'h30_0001;
        mem[ea(52'h20_0000, 6)]  = 64'h8_C000_0081;
        mem[ea(52'h30_0000, 3)]  = 64'h40_0001;
        mem[ea(52'h30_0000, 5)]  = 64'h4060_0081;
        mem[ea(52'h30_0000, 8)]  = 64'h50_0000;
        mem[ea(52'h40_0000, 4)]  = 64'h8000_0000_1234_5001;
        mem[ea(52'h40_0000, 10)] = 64'h777_7081;
        // five-level top tables
        mem[ea(52'h60_0000, 3)]  = 64'h10_0001;
        mem[ea(52'h60_0000, 4)]  = 64'h70_0001;
        mem[ea(52'h60_0000, 5)]  = 64'hA0_0081;
        mem[ea(52'h70_0000, 2)]  = 64'h2_0000_0000_0081;

        repeat (3) @(negedge clk);
        check(req_ready == 1'b0 || res_valid == 1'b0, "R1 reset", {63'd0, res_valid}, 64'd0);
        check(mem_rd_valid == 1'b0, "R2 reset", {63'd0, mem_rd_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 idle after reset", {63'd0, req_ready}, 64'd1);
        check(res_valid == 1'b0, "R11 no result after reset", {63'd0, res_valid}, 64'd0);

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            stall = i % 3;
            gap   = i % 2;
            send(VECS[i].va, VECS[i].five);
            wait_res();
            check(res_fault == VECS[i].fault, vtag(i), {63'd0, res_fault}, {63'd0, VECS[i].fault});
            check(res_paddr == VECS[i].pa, vtag(i), {12'd0, res_paddr}, {12'd0, VECS[i].pa});
            check(res_size == VECS[i].size, vtag(i), {62'd0, res_size}, {62'd0, VECS[i].size});
            check(reads == int'(VECS[i].reads), "R4 read count", 64'(reads), 64'(VECS[i].reads));
            if (i == 0)
                check(first_addr == 52'h10_0008, "R3 first entry address",
                      {12'd0, first_addr}, 64'h10_0008);
            if (i == 8)
                check(first_addr == 52'h60_0018, "R3 five-level top index",
                      {12'd0, first_addr}, 64'h60_0018);
            ack();
        end

        // result held while a new request waits
        stall = 0;
        gap   = 0;
        send(64'h0000_0080_80A1_2345, 1'b0);
        wait_res();
        req_vaddr = 64'h0000_0081_8123_4567;
        req_five  = 1'b0;
        req_root  = ROOT4;
        req_valid = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(res_valid == 1'b1, "R11 held valid", {63'd0, res_valid}, 64'd1);
            check(res_paddr == 52'h4061_2345, "R11 held paddr", {12'd0, res_paddr}, 64'h4061_2345);
            check(req_ready == 1'b0, "R1 busy while result pending", {63'd0, req_ready}, 64'd0);
        end
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        check(req_ready == 1'b1, "R1 idle after ack", {63'd0, req_ready}, 64'd1);
        reads = 0;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R1 waiting request taken", {63'd0, req_ready}, 64'd0);
        wait_res();
        check(res_paddr == 52'h8_C123_4567, "R7 queued request",
              {12'd0, res_paddr}, 64'h8_C123_4567);
        check(res_size == 2'd2, "R7 queued size", {62'd0, res_size}, 64'd2);
        ack();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule